// File: doc/BRIEF.md
# 8-bit dual-compare timer

This block is one 8-bit up-counting timer channel with a byte-wide register port. A shared, free-running prescaler offers three count rates, and a 3-bit rate field in the control register picks one of them or stops the count. Two compare constants are checked against the counter on every cycle. A hit is reported when the counter is greater than or equal to the constant, not only when it is equal. Each hit sets a sticky status flag, and a 2-bit field in the control register can make either hit reset the counter.

A wrap of the counter from its maximum value to zero sets a third sticky flag. Software clears a flag by writing a zero to its status bit. Each flag drives an interrupt-request output that is gated by an enable bit in the control register. That enable bit sits in the same position as the flag it gates. Register reads are registered, so data appears one cycle after the address is presented.

Top module: `tmr8_timer`

## Requirements
- R1: After reset, control, status and counter read 0x00, and both compare constants read 0xFF.
- R2: The control field bits 2:0 selects the count rate: 1 means one increment every 8 cycles, 2 every 64 cycles and 3 every 8192 cycles. The values 0 and 4 to 7 hold the counter.
- R3: An increment from 0xFF gives 0x00 and sets status bit 5 (overflow). Overflow is set only when the increment actually happens.
- R4: While counter >= constant A, status bit 6 is set. If control bits 4:3 are 01, the counter becomes 0 on the next cycle.
- R5: While counter >= constant B, status bit 7 is set. If control bits 4:3 are 10, the counter becomes 0 on the next cycle.
- R6: With control bits 4:3 at 00 or 11, a compare hit sets its flag but never resets the counter.
- R7: Status flags are sticky. Writing 0 to a flag bit clears it, and writing 1 leaves it unchanged. A set condition in the same cycle wins over the clear.
- R8: Each interrupt output is 1 exactly while its flag and its enable are both 1. The enables are control bit 7 for compare B, bit 6 for compare A and bit 5 for overflow.
- R9: A bus write to the counter takes priority over both the increment and a compare clear in the same cycle.
- R10: Register map, byte-wide: 0 control, 1 status, 2 constant A, 3 constant B, 4 counter. Read data is registered (one cycle latency). Addresses 5 to 7 and status bits 4:0 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data for the address of the previous cycle |
| irq_cmpb | output | 1 | Compare-B interrupt request |
| irq_cmpa | output | 1 | Compare-A interrupt request |
| irq_ovf | output | 1 | Overflow interrupt request |

## Verification
The assertions check the following on every cycle:
- a compare hit leads to its flag on the next cycle;
- a selected clear leads to a zero count;
- a counter write lands ahead of any increment or clear;
- a stopped rate leaves the count untouched unless a write or a clear acts on it;
- the overflow flag can only rise from a count of 0xFF;
- a flag can only fall after a status write of zero.

Only the bench scenarios can show the actual spacing of increments for each rate, the highest count reached under each clear mode, and the readback of every register. They also show the interrupt gating, and the ordering of a counter write against a pending clear. The bench compares these against a behavioural model on every cycle.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL = 3'd0,
    REG_STAT = 3'd1,
    REG_CMPA = 3'd2,
    REG_CMPB = 3'd3,
    REG_CNT  = 3'd4
  } reg_sel_e;

  // clear-select codes (control bits 4:3)
  localparam logic [1:0] CLR_ON_A = 2'b01;
  localparam logic [1:0] CLR_ON_B = 2'b10;

  // internal flag vector order: {cmpb, cmpa, ovf}; maps to status/enable bits 7:5
  localparam int FLAG_LSB = 5;
  localparam int NFLAG    = 3;
endpackage

// File: rtl/tmr8_prescaler.sv
module tmr8_prescaler #(
  parameter int DIV1_LOG = 3,
  parameter int DIV2_LOG = 6,
  parameter int DIV3_LOG = 13
) (
  input  logic       clk,
  input  logic       rst,
  output logic [2:0] tick
);
  localparam int PS_W = DIV3_LOG;

  logic [PS_W-1:0] ps_q;

  always_ff @(posedge clk) begin
    if (rst) ps_q <= '0;
    else     ps_q <= ps_q + 1'b1;
  end

  // each tap pulses for one cycle when its low bits are all ones
  for (genvar i = 0; i < 3; i++) begin : g_tap
    localparam int L = (i == 0) ? DIV1_LOG : (i == 1) ? DIV2_LOG : DIV3_LOG;
    assign tick[i] = &ps_q[L-1:0];
  end
endmodule

// File: rtl/tmr8_match.sv
module tmr8_match #(
  parameter int         W        = 8,
  parameter logic [1:0] CLR_CODE = 2'b01
) (
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] konst,
  input  logic [1:0]   clr_sel,
  output logic         hit,
  output logic         clr_req
);
  assign hit     = (cnt >= konst);
  assign clr_req = hit && (clr_sel == CLR_CODE);
endmodule

// File: rtl/tmr8_counter.sv
module tmr8_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt_q,
  output logic         wrap
);
  // priority: bus load, then compare clear, then increment
  assign wrap = inc && !load && !clr && (&cnt_q);

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (clr)  cnt_q <= '0;
    else if (inc)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tmr8_timer.sv
module tmr8_timer
  import tmr8_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int DIV1_LOG = 3,
  parameter int DIV2_LOG = 6,
  parameter int DIV3_LOG = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_cmpb,
  output logic              irq_cmpa,
  output logic              irq_ovf
);
  localparam logic [1:0] CLR_CODES [2] = '{CLR_ON_A, CLR_ON_B};

  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] cmp_q [2];
  logic [NFLAG-1:0]  flags_q;
  logic [DATA_W-1:0] cnt_q;
  logic [2:0]        tick;
  logic [1:0]        hit, clr_req;
  logic              tick_sel, wrap;

  wire [2:0] clk_sel = ctrl_q[2:0];
  wire [1:0] clr_sel = ctrl_q[4:3];
  wire [NFLAG-1:0] irq_en = ctrl_q[FLAG_LSB +: NFLAG];

  wire wr_ctrl = bus_wr && (bus_addr == REG_CTRL);
  wire wr_stat = bus_wr && (bus_addr == REG_STAT);
  wire wr_cnt  = bus_wr && (bus_addr == REG_CNT);

  tmr8_prescaler #(
    .DIV1_LOG(DIV1_LOG), .DIV2_LOG(DIV2_LOG), .DIV3_LOG(DIV3_LOG)
  ) u_pre (
    .clk(clk), .rst(rst), .tick(tick)
  );

  always_comb begin
    case (clk_sel)
      3'd1:    tick_sel = tick[0];
      3'd2:    tick_sel = tick[1];
      3'd3:    tick_sel = tick[2];
      default: tick_sel = 1'b0;
    endcase
  end

  for (genvar c = 0; c < 2; c++) begin : g_cmp
    wire wr_k = bus_wr && (bus_addr == ((c == 0) ? REG_CMPA : REG_CMPB));

    always_ff @(posedge clk) begin
      if (rst)       cmp_q[c] <= '1;
      else if (wr_k) cmp_q[c] <= bus_wdata;
    end

    tmr8_match #(.W(DATA_W), .CLR_CODE(CLR_CODES[c])) u_match (
      .cnt(cnt_q), .konst(cmp_q[c]), .clr_sel(clr_sel),
      .hit(hit[c]), .clr_req(clr_req[c])
    );
  end

  tmr8_counter #(.W(DATA_W)) u_cnt (
    .clk(clk), .rst(rst),
    .load(wr_cnt), .load_val(bus_wdata),
    .clr(|clr_req), .inc(tick_sel),
    .cnt_q(cnt_q), .wrap(wrap)
  );

  always_ff @(posedge clk) begin
    if (rst)          ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= bus_wdata;
  end

  // sticky flags: a zero written clears, a set condition wins
  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= (wr_stat ? (flags_q & bus_wdata[FLAG_LSB +: NFLAG]) : flags_q)
                        | {hit[1], hit[0], wrap};
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else begin
      case (bus_addr)
        REG_CTRL: bus_rdata <= ctrl_q;
        REG_STAT: bus_rdata <= {flags_q, {FLAG_LSB{1'b0}}};
        REG_CMPA: bus_rdata <= cmp_q[0];
        REG_CMPB: bus_rdata <= cmp_q[1];
        REG_CNT:  bus_rdata <= cnt_q;
        default:  bus_rdata <= '0;
      endcase
    end
  end

  assign irq_cmpb = flags_q[2] & irq_en[2];
  assign irq_cmpa = flags_q[1] & irq_en[1];
  assign irq_ovf  = flags_q[0] & irq_en[0];
endmodule

module tmr8_timer_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         bus_wr,
  input logic [2:0]   bus_addr,
  input logic [W-1:0] bus_wdata,
  input logic [7:0]   ctrl_q,
  input logic [W-1:0] cnt_q,
  input logic [W-1:0] cmpa,
  input logic [W-1:0] cmpb,
  input logic [2:0]   flags_q
);
  wire wr_cnt   = bus_wr && (bus_addr == 3'd4);
  wire wr_stat  = bus_wr && (bus_addr == 3'd1);
  wire clr_a    = (ctrl_q[4:3] == 2'b01) && (cnt_q >= cmpa);
  wire clr_b    = (ctrl_q[4:3] == 2'b10) && (cnt_q >= cmpb);
  wire stopped  = (ctrl_q[2:0] == 3'd0) || (ctrl_q[2:0] > 3'd3);

  AST_RESET_VALUES: assert property (@(posedge clk)
    rst |=> (ctrl_q == 8'h00 && cnt_q == '0 && flags_q == 3'b000 && cmpa == '1 && cmpb == '1)); // R1

  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (stopped && !wr_cnt && !clr_a && !clr_b) |=> $stable(cnt_q)); // R2

  AST_OVF_FROM_MAX: assert property (@(posedge clk) disable iff (rst)
    $rose(flags_q[0]) |-> ($past(cnt_q) == '1)); // R3

  AST_CMPA_FLAG: assert property (@(posedge clk) disable iff (rst)
    (cnt_q >= cmpa) |=> flags_q[1]); // R4

  AST_CMPA_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (clr_a && !wr_cnt) |=> (cnt_q == '0)); // R4

  AST_CMPB_FLAG: assert property (@(posedge clk) disable iff (rst)
    (cnt_q >= cmpb) |=> flags_q[2]); // R5

  AST_CMPB_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (clr_b && !wr_cnt) |=> (cnt_q == '0)); // R5

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    ($fell(flags_q[1]) || $fell(flags_q[2]) || $fell(flags_q[0])) |-> $past(wr_stat)); // R7

  AST_WRITE_PRIORITY: assert property (@(posedge clk) disable iff (rst)
    wr_cnt |=> (cnt_q == $past(bus_wdata))); // R9
endmodule

bind tmr8_timer tmr8_timer_chk #(.W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .ctrl_q(ctrl_q), .cnt_q(cnt_q), .cmpa(cmp_q[0]), .cmpb(cmp_q[1]), .flags_q(flags_q)
);

// File: tb/sim_tmr8_timer.sv
module sim_tmr8_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       irq_cmpb, irq_cmpa, irq_ovf;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit model_on = 1'b0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  tmr8_timer u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_cmpb(irq_cmpb), .irq_cmpa(irq_cmpa), .irq_ovf(irq_ovf)
  );

  // behavioural reference model
  int m_ps, m_ctrl, m_cnt, m_ca, m_cb, m_rd;
  bit m_fb, m_fa, m_fo;
  int sel, csel, nxt;
  bit tk, ha, hb, clr, ovf, wcnt;

  always @(posedge clk) begin
    if (rst) begin
      m_ps = 0; m_ctrl = 0; m_cnt = 0; m_ca = 255; m_cb = 255; m_rd = 0;
      m_fb = 0; m_fa = 0; m_fo = 0;
    end else begin
      sel  = m_ctrl % 8;
      csel = (m_ctrl / 8) % 4;
      tk   = (sel == 1) ? (m_ps % 8 == 7) : (sel == 2) ? (m_ps % 64 == 63) :
             (sel == 3) ? (m_ps % 8192 == 8191) : 1'b0;
      ha   = m_cnt >= m_ca;
      hb   = m_cnt >= m_cb;
      clr  = (csel == 1 && ha) || (csel == 2 && hb);
      wcnt = bus_wr && bus_addr == 3'd4;
      case (bus_addr)
        3'd0: m_rd = m_ctrl;
        3'd1: m_rd = (m_fb ? 128 : 0) + (m_fa ? 64 : 0) + (m_fo ? 32 : 0);
        3'd2: m_rd = m_ca;
        3'd3: m_rd = m_cb;
        3'd4: m_rd = m_cnt;
        default: m_rd = 0;
      endcase
      ovf = !wcnt && !clr && tk && m_cnt == 255;
      if (wcnt) nxt = bus_wdata;
      else if (clr) nxt = 0;
      else if (tk) nxt = (m_cnt + 1) % 256;
      else nxt = m_cnt;
      if (bus_wr && bus_addr == 3'd1) begin
        if (!bus_wdata[7]) m_fb = 0;
        if (!bus_wdata[6]) m_fa = 0;
        if (!bus_wdata[5]) m_fo = 0;
      end
      if (hb) m_fb = 1;
      if (ha) m_fa = 1;
      if (ovf) m_fo = 1;
      if (bus_wr && bus_addr == 3'd0) m_ctrl = bus_wdata;
      if (bus_wr && bus_addr == 3'd2) m_ca = bus_wdata;
      if (bus_wr && bus_addr == 3'd3) m_cb = bus_wdata;
      m_cnt = nxt;
      m_ps = (m_ps + 1) % 8192;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (model_on && !rst) begin
      chk(cur_req, "model rdata", int'(bus_rdata), m_rd);
      chk(cur_req, "model irq_cmpb", int'(irq_cmpb), int'(m_fb && m_ctrl[7]));
      chk(cur_req, "model irq_cmpa", int'(irq_cmpa), int'(m_fa && m_ctrl[6]));
      chk(cur_req, "model irq_ovf", int'(irq_ovf), int'(m_fo && m_ctrl[5]));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<190000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wr(input int a, input int d);
    bus_wr = 1'b1; bus_addr = 3'(a); bus_wdata = 8'(d);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    bus_addr = 3'(a);
    @(negedge clk);
    @(negedge clk);
    v = int'(bus_rdata);
  endtask

  task automatic gap(output int g);
    int prev;
    bus_addr = 3'd4;
    @(negedge clk); @(negedge clk);
    prev = int'(bus_rdata);
    while (int'(bus_rdata) == prev) @(negedge clk);
    prev = int'(bus_rdata);
    g = 0;
    while (int'(bus_rdata) == prev) begin
      @(negedge clk);
      g++;
    end
  endtask

  task automatic peak(input int n, output int mx);
    bus_addr = 3'd4;
    mx = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (int'(bus_rdata) > mx) mx = int'(bus_rdata);
    end
  endtask

  initial begin
    int v, v2, g, mx;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_on = 1'b1;

    cur_req = "R1";
    rd(0, v); chk("R1", "ctrl reset", v, 8'h00);
    rd(1, v); chk("R1", "status reset", v, 8'h00);
    rd(2, v); chk("R1", "constA reset", v, 8'hFF);
    rd(3, v); chk("R1", "constB reset", v, 8'hFF);
    rd(4, v); chk("R1", "counter reset", v, 8'h00);

    cur_req = "R10";
    rd(5, v); chk("R10", "addr5", v, 0);
    rd(6, v); chk("R10", "addr6", v, 0);
    rd(7, v); chk("R10", "addr7", v, 0);
    wr(0, 8'hA5); rd(0, v); chk("R10", "ctrl readback", v, 8'hA5);
    wr(0, 8'h00);

    cur_req = "R2";
    wr(4, 0); wr(0, 1);
    gap(g); chk("R2", "rate 8 gap", g, 8);
    wr(0, 2);
    gap(g); chk("R2", "rate 64 gap", g, 64);
    wr(0, 3);
    gap(g); chk("R2", "rate 8192 gap", g, 8192);
    wr(0, 0);
    rd(4, v); repeat (100) @(negedge clk); rd(4, v2);
    chk("R2", "sel 0 holds", v2, v);
    wr(0, 5);
    rd(4, v); repeat (100) @(negedge clk); rd(4, v2);
    chk("R2", "sel 5 holds", v2, v);

    cur_req = "R3";
    wr(0, 0); wr(1, 0); wr(4, 8'hF0); wr(0, 1);
    repeat (200) @(negedge clk);
    rd(1, v); chk("R3", "status after wrap", v, 8'hE0);
    rd(4, v); chk("R3", "counter wrapped low", int'(v < 16), 1);

    cur_req = "R7";
    wr(0, 0);
    wr(1, 8'hFF); rd(1, v); chk("R7", "write ones no effect", v, 8'hE0);
    wr(1, 8'h60); rd(1, v); chk("R7", "clear B only", v, 8'h60);
    wr(1, 8'h00); rd(1, v); chk("R7", "clear all", v, 8'h00);

    cur_req = "R8";
    wr(2, 3); wr(0, 8'h40);
    @(negedge clk);
    chk("R8", "irq_cmpa on", int'(irq_cmpa), 1);
    chk("R8", "irq_cmpb off", int'(irq_cmpb), 0);
    chk("R8", "irq_ovf off", int'(irq_ovf), 0);
    wr(0, 8'h00); @(negedge clk);
    chk("R8", "irq_cmpa disabled", int'(irq_cmpa), 0);
    wr(2, 8'hFF); wr(1, 0); wr(0, 8'h40); @(negedge clk);
    chk("R8", "irq_cmpa flag cleared", int'(irq_cmpa), 0);

    cur_req = "R4";
    wr(0, 0); wr(2, 8'h10); wr(4, 0); wr(1, 0); wr(0, 8'h09);
    peak(700, mx); chk("R4", "peak with clear on A", mx, 8'h10);
    wr(0, 0); rd(1, v); chk("R4", "flag A only", v, 8'h40);

    cur_req = "R5";
    wr(2, 8'hFF); wr(3, 8'h20); wr(4, 0); wr(1, 0); wr(0, 8'h11);
    peak(1000, mx); chk("R5", "peak with clear on B", mx, 8'h20);
    wr(0, 0); rd(1, v); chk("R5", "flag B only", v, 8'h80);

    cur_req = "R6";
    wr(2, 5); wr(3, 6); wr(4, 0); wr(0, 8'h19);
    peak(300, mx); chk("R6", "no clear with code 11", int'(mx >= 10), 1);
    wr(0, 0); rd(1, v); chk("R6", "flags A and B set", v & 8'hC0, 8'hC0);

    cur_req = "R9";
    wr(2, 8'hFF); wr(3, 8'hFF); wr(0, 1);
    bus_wr = 1'b1; bus_addr = 3'd4; bus_wdata = 8'h42;
    repeat (20) @(negedge clk);
    bus_wr = 1'b0;
    @(negedge clk);
    chk("R9", "write beats increment", int'(bus_rdata), 8'h42);
    wr(0, 0); wr(2, 8'h10); wr(0, 8'h08);
    bus_wr = 1'b1; bus_addr = 3'd4; bus_wdata = 8'h30;
    @(negedge clk);
    bus_wr = 1'b0;
    @(negedge clk);
    chk("R9", "write beats clear", int'(bus_rdata), 8'h30);
    @(negedge clk);
    chk("R9", "clear follows write", int'(bus_rdata), 8'h00);

    repeat (5) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule